// File: doc/BRIEF.md
# Multicarrier Transmit Frame Assembler

This block builds the time-domain transmit stream of a multicarrier spread-spectrum downlink. It takes spread data chips from upstream, lays them onto the used subcarrier bins of each multicarrier symbol, and forces the DC bin and the band-edge bins to zero. It hands the bins to an external inverse FFT, collects the time-domain result, and sends every symbol out with a cyclic prefix in front. The prefix is the tail of the symbol's useful part, replayed before the useful part itself.

Each frame opens with exactly one pilot symbol. The pilot puts one fixed amplitude on every used bin and takes no chips. A programmable number of data symbols follows it, and then the next frame begins. Two numerologies are available: a 64-bin symbol with 48 used bins and a 16-sample prefix, and a 256-bin symbol with 192 used bins and a 40-sample prefix. The numerology and the data-symbol count are taken once per frame, at the start of its pilot symbol. When chips run out partway through a frame, the block waits for more. It never inserts filler bins.

Top module: `mc_frame_asm`

## Requirements
- R1: While reset is applied and right after it, `smp_valid` is low. The first bin offered to the transform is bin 0 of a pilot symbol: valid, value zero, not last. `chip_ready` stays low.
- R2: Each symbol offers its bins to the transform in index order 0 to NC-1, and `fft_in_last` marks bin NC-1. The used bins are 1..NCU/2 and NC-NCU/2..NC-1. Every other bin, DC included, is zero.
- R3: The first symbol of every frame is a pilot. Every used bin carries real part 8192 (PILOT_AMP) and imaginary part 0, in both numerologies. The pilot takes no chips.
- R4: After the pilot come exactly Ns data symbols. Their used bins take successive chips in ascending bin order. The frame then repeats.
- R5: Each output symbol is the last G transform samples of the symbol, then all NC of them in order. cfg_mode 0 gives NC=64, NCU=48, G=16. cfg_mode 1 gives NC=256, NCU=192, G=40.
- R6: `smp_sym_start` is high on the first prefix sample of every symbol. `smp_frame_start` is high only on the first prefix sample of a pilot symbol.
- R7: When no chip is offered for a data bin, `fft_in_valid` is low. Once a chip arrives, the block resumes at that same bin.
- R8: While `smp_valid` is high and `smp_ready` is low, the output sample and its markers hold. The transform output is not accepted while a symbol plays out.
- R9: cfg_mode and cfg_nsym are sampled at the start of each frame's pilot symbol. A change made partway through a frame takes effect from the next frame.
- R10: With Ns equal to 0, every frame consists of the pilot symbol alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Numerology: 0 = 64-bin, 1 = 256-bin |
| cfg_nsym | input | NS_W | Data symbols per frame |
| chip_valid | input | 1 | Chip offered |
| chip_ready | output | 1 | Chip taken |
| chip_re | input | SMP_W | Chip real part |
| chip_im | input | SMP_W | Chip imaginary part |
| fft_in_valid | output | 1 | Bin offered to transform |
| fft_in_ready | input | 1 | Transform takes bin |
| fft_in_re | output | SMP_W | Bin real part |
| fft_in_im | output | SMP_W | Bin imaginary part |
| fft_in_last | output | 1 | Last bin of symbol |
| fft_out_valid | input | 1 | Transform sample offered |
| fft_out_ready | output | 1 | Transform sample taken |
| fft_out_re | input | SMP_W | Transform sample real part |
| fft_out_im | input | SMP_W | Transform sample imaginary part |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Output sample taken |
| smp_re | output | SMP_W | Output sample real part |
| smp_im | output | SMP_W | Output sample imaginary part |
| smp_frame_start | output | 1 | First sample of a frame |
| smp_sym_start | output | 1 | First sample of a symbol |

## Verification
The external transform is modelled as an identity that returns the bins it received. Every output sample can therefore be predicted from the bin map, the chip order and the prefix rule. Both numerologies are run with several data-symbol counts, including zero. The 64-bin short frames separate pilot handling from data placement. The 256-bin frames expose a wrong prefix length or a wrong edge-bin boundary. Gapped chip supply, a throttled transform and a stalling sink each shift where the stalls land, which tells a true stall apart from a skipped or repeated bin. A numerology change partway through a frame shows whether the configuration is held per frame.

// File: rtl/mcfa_pkg.sv
`timescale 1ns/1ps
package mcfa_pkg;

    typedef enum logic {
        NUM_A = 1'b0,
        NUM_B = 1'b1
    } numer_e;

    typedef enum logic {
        GB_FILL = 1'b0,
        GB_PLAY = 1'b1
    } gb_state_e;

    // A bin carries payload unless it is DC or inside the empty band edge.
    function automatic logic bin_used(input int unsigned k,
                                      input int unsigned nc,
                                      input int unsigned ncu);
        int unsigned half;
        half = ncu / 2;
        return (k != 0) && ((k <= half) || (k >= nc - half));
    endfunction

endpackage

// File: rtl/mcfa_frame_seq.sv
`timescale 1ns/1ps
module mcfa_frame_seq
    import mcfa_pkg::*;
#(
    parameter int NS_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  numer_e          cfg_mode,
    input  logic [NS_W-1:0] cfg_nsym,
    input  logic            sym_begin,
    input  logic            sym_done,
    output numer_e          eff_mode,
    output logic            is_pilot
);

    typedef struct packed {
        numer_e          mode;
        logic [NS_W-1:0] nsym;
        logic [NS_W-1:0] idx;
        logic            active;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        if (sym_begin) begin
            d.active = 1'b1;
            if (q.idx == '0) begin
                d.mode = cfg_mode;
                d.nsym = cfg_nsym;
            end
        end
        if (sym_done) begin
            d.active = 1'b0;
            if (q.idx >= q.nsym) begin
                d.idx = '0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: NUM_A, nsym: '0, idx: '0, active: 1'b0};
        end else begin
            q <= d;
        end
    end

    // Before the pilot starts, the live setting applies; afterwards the latched one.
    assign eff_mode = (q.idx == '0 && !q.active) ? cfg_mode : q.mode;
    assign is_pilot = (q.idx == '0);

endmodule

// File: rtl/mcfa_bin_mapper.sv
`timescale 1ns/1ps
module mcfa_bin_mapper
    import mcfa_pkg::*;
#(
    parameter int SMP_W     = 16,
    parameter int NC_A      = 64,
    parameter int NCU_A     = 48,
    parameter int NC_B      = 256,
    parameter int NCU_B     = 192,
    parameter int BIN_W     = 8,
    parameter int PILOT_AMP = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  numer_e           mode,
    input  logic             is_pilot,
    input  logic             chip_valid,
    output logic             chip_ready,
    input  logic [SMP_W-1:0] chip_re,
    input  logic [SMP_W-1:0] chip_im,
    output logic             bin_valid,
    input  logic             bin_ready,
    output logic [SMP_W-1:0] bin_re,
    output logic [SMP_W-1:0] bin_im,
    output logic             bin_last,
    output logic             sym_begin,
    output logic             sym_done
);

    localparam logic [BIN_W-1:0] LAST_A = BIN_W'(NC_A - 1);
    localparam logic [BIN_W-1:0] LAST_B = BIN_W'(NC_B - 1);
    localparam logic [SMP_W-1:0] PILOT  = SMP_W'(PILOT_AMP);

    typedef struct packed {
        logic [BIN_W-1:0] bin;
    } map_t;

    map_t d, q;
    logic used;
    logic take_chip;
    logic fire;

    always_comb begin
        d         = q;
        used      = (mode == NUM_B) ? bin_used(32'(q.bin), NC_B, NCU_B)
                                    : bin_used(32'(q.bin), NC_A, NCU_A);
        take_chip = used && !is_pilot;
        bin_last  = (q.bin == ((mode == NUM_B) ? LAST_B : LAST_A));
        bin_valid = take_chip ? chip_valid : 1'b1;
        chip_ready = take_chip && bin_ready;
        if (!used) begin
            bin_re = '0;
            bin_im = '0;
        end else if (is_pilot) begin
            bin_re = PILOT;
            bin_im = '0;
        end else begin
            bin_re = chip_re;
            bin_im = chip_im;
        end
        fire      = bin_valid && bin_ready;
        sym_begin = fire && (q.bin == '0);
        sym_done  = fire && bin_last;
        if (fire) begin
            d.bin = bin_last ? '0 : q.bin + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{bin: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mcfa_guard_buf.sv
`timescale 1ns/1ps
module mcfa_guard_buf
    import mcfa_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int NC_A   = 64,
    parameter int G_A    = 16,
    parameter int NC_B   = 256,
    parameter int G_B    = 40,
    parameter int NC_MAX = 256,
    parameter int BIN_W  = 8,
    parameter int PLAY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  numer_e           mode,
    input  logic             is_pilot,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SMP_W-1:0] in_re,
    input  logic [SMP_W-1:0] in_im,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SMP_W-1:0] out_re,
    output logic [SMP_W-1:0] out_im,
    output logic             out_frame_start,
    output logic             out_sym_start,
    output logic             sym_begin,
    output logic             sym_done
);

    typedef struct packed {
        gb_state_e         st;
        logic [BIN_W-1:0]  wr;
        logic [PLAY_W-1:0] play;
    } gb_t;

    gb_t d, q;
    logic [2*SMP_W-1:0] mem [NC_MAX];
    logic [PLAY_W-1:0]  nc_w;
    logic [PLAY_W-1:0]  g_w;
    logic [PLAY_W-1:0]  addr_w;
    logic               wr_fire;
    logic               out_fire;
    logic               wr_last;
    logic               play_last;

    always_comb begin
        d         = q;
        nc_w      = (mode == NUM_B) ? PLAY_W'(NC_B) : PLAY_W'(NC_A);
        g_w       = (mode == NUM_B) ? PLAY_W'(G_B)  : PLAY_W'(G_A);
        // Prefix positions replay the tail; the rest walk the whole symbol.
        addr_w    = (q.play < g_w) ? q.play + nc_w - g_w : q.play - g_w;
        in_ready  = (q.st == GB_FILL);
        out_valid = (q.st == GB_PLAY);
        wr_fire   = in_ready && in_valid;
        out_fire  = out_valid && out_ready;
        wr_last   = (q.wr == BIN_W'(nc_w - PLAY_W'(1)));
        play_last = (q.play == nc_w + g_w - PLAY_W'(1));
        sym_begin = wr_fire && (q.wr == '0);
        sym_done  = out_fire && play_last;
        out_sym_start   = out_valid && (q.play == '0);
        out_frame_start = out_sym_start && is_pilot;
        if (wr_fire) begin
            if (wr_last) begin
                d.st   = GB_PLAY;
                d.wr   = '0;
                d.play = '0;
            end else begin
                d.wr = q.wr + 1'b1;
            end
        end
        if (out_fire) begin
            if (play_last) begin
                d.st = GB_FILL;
            end else begin
                d.play = q.play + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: GB_FILL, wr: '0, play: '0};
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[q.wr] <= {in_re, in_im};
        end
    end

    assign {out_re, out_im} = mem[addr_w[BIN_W-1:0]];

endmodule

// File: rtl/mc_frame_asm.sv
`timescale 1ns/1ps
module mc_frame_asm
    import mcfa_pkg::*;
#(
    parameter int SMP_W     = 16,
    parameter int NS_W      = 10,
    parameter int NC_A      = 64,
    parameter int NCU_A     = 48,
    parameter int G_A       = 16,
    parameter int NC_B      = 256,
    parameter int NCU_B     = 192,
    parameter int G_B       = 40,
    parameter int PILOT_AMP = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic [NS_W-1:0]  cfg_nsym,
    input  logic             chip_valid,
    output logic             chip_ready,
    input  logic [SMP_W-1:0] chip_re,
    input  logic [SMP_W-1:0] chip_im,
    output logic             fft_in_valid,
    input  logic             fft_in_ready,
    output logic [SMP_W-1:0] fft_in_re,
    output logic [SMP_W-1:0] fft_in_im,
    output logic             fft_in_last,
    input  logic             fft_out_valid,
    output logic             fft_out_ready,
    input  logic [SMP_W-1:0] fft_out_re,
    input  logic [SMP_W-1:0] fft_out_im,
    output logic             smp_valid,
    input  logic             smp_ready,
    output logic [SMP_W-1:0] smp_re,
    output logic [SMP_W-1:0] smp_im,
    output logic             smp_frame_start,
    output logic             smp_sym_start
);

    localparam int NC_MAX = (NC_A > NC_B) ? NC_A : NC_B;
    localparam int G_MAX  = (G_A > G_B) ? G_A : G_B;
    localparam int BIN_W  = $clog2(NC_MAX);
    localparam int PLAY_W = $clog2(NC_MAX + G_MAX + 1);

    numer_e live_mode;
    numer_e map_mode;
    numer_e gb_mode;
    logic   map_pilot;
    logic   gb_pilot;
    logic   map_begin;
    logic   map_done;
    logic   gb_begin;
    logic   gb_done;

    assign live_mode = numer_e'(cfg_mode);

    mcfa_frame_seq #(.NS_W(NS_W)) u_map_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (live_mode),
        .cfg_nsym  (cfg_nsym),
        .sym_begin (map_begin),
        .sym_done  (map_done),
        .eff_mode  (map_mode),
        .is_pilot  (map_pilot)
    );

    mcfa_bin_mapper #(
        .SMP_W     (SMP_W),
        .NC_A      (NC_A),
        .NCU_A     (NCU_A),
        .NC_B      (NC_B),
        .NCU_B     (NCU_B),
        .BIN_W     (BIN_W),
        .PILOT_AMP (PILOT_AMP)
    ) u_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (map_mode),
        .is_pilot   (map_pilot),
        .chip_valid (chip_valid),
        .chip_ready (chip_ready),
        .chip_re    (chip_re),
        .chip_im    (chip_im),
        .bin_valid  (fft_in_valid),
        .bin_ready  (fft_in_ready),
        .bin_re     (fft_in_re),
        .bin_im     (fft_in_im),
        .bin_last   (fft_in_last),
        .sym_begin  (map_begin),
        .sym_done   (map_done)
    );

    mcfa_frame_seq #(.NS_W(NS_W)) u_gb_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (live_mode),
        .cfg_nsym  (cfg_nsym),
        .sym_begin (gb_begin),
        .sym_done  (gb_done),
        .eff_mode  (gb_mode),
        .is_pilot  (gb_pilot)
    );

    mcfa_guard_buf #(
        .SMP_W  (SMP_W),
        .NC_A   (NC_A),
        .G_A    (G_A),
        .NC_B   (NC_B),
        .G_B    (G_B),
        .NC_MAX (NC_MAX),
        .BIN_W  (BIN_W),
        .PLAY_W (PLAY_W)
    ) u_guard (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode            (gb_mode),
        .is_pilot        (gb_pilot),
        .in_valid        (fft_out_valid),
        .in_ready        (fft_out_ready),
        .in_re           (fft_out_re),
        .in_im           (fft_out_im),
        .out_valid       (smp_valid),
        .out_ready       (smp_ready),
        .out_re          (smp_re),
        .out_im          (smp_im),
        .out_frame_start (smp_frame_start),
        .out_sym_start   (smp_sym_start),
        .sym_begin       (gb_begin),
        .sym_done        (gb_done)
    );

endmodule

// File: rtl/mcfa_checker.sv
`timescale 1ns/1ps
module mcfa_checker #(
    parameter int SMP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_valid,
    input logic             chip_ready,
    input logic             fft_in_valid,
    input logic             fft_in_ready,
    input logic             fft_out_ready,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic [SMP_W-1:0] smp_re,
    input logic [SMP_W-1:0] smp_im,
    input logic             smp_frame_start,
    input logic             smp_sym_start
);

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !smp_valid);

    // R8
    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_re) && $stable(smp_im)
                                       && $stable(smp_sym_start) && $stable(smp_frame_start)));

    // R8
    a_r8_no_fill_during_play: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !fft_out_ready);

    // R6
    a_r6_frame_marks_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        smp_frame_start |-> (smp_sym_start && smp_valid));

    // R7
    a_r7_chip_moves_with_bin: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && chip_ready) |-> (fft_in_valid && fft_in_ready));

    // R7
    a_r7_dry_means_no_bin: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_ready && !chip_valid) |-> !fft_in_valid);

endmodule

bind mc_frame_asm mcfa_checker #(.SMP_W(SMP_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .chip_valid      (chip_valid),
    .chip_ready      (chip_ready),
    .fft_in_valid    (fft_in_valid),
    .fft_in_ready    (fft_in_ready),
    .fft_out_ready   (fft_out_ready),
    .smp_valid       (smp_valid),
    .smp_ready       (smp_ready),
    .smp_re          (smp_re),
    .smp_im          (smp_im),
    .smp_frame_start (smp_frame_start),
    .smp_sym_start   (smp_sym_start)
);

// File: tb/mc_frame_asm_test.sv
`timescale 1ns/1ps
module mc_frame_asm_test;

    localparam int PILOT = 8192;

    typedef struct packed {
        logic       mode;
        logic [7:0] ns;
        logic [7:0] frames;
        logic       gap;
        logic       bp;
        logic       thr;
    } case_t;

    // mode, Ns, frames, chip gaps, sink backpressure, transform throttle
    localparam case_t CASES [5] = '{
        '{1'b0, 8'd2, 8'd2, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'd1, 8'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'd3, 8'd1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 8'd0, 8'd3, 1'b0, 1'b1, 1'b0},
        '{1'b0, 8'd1, 8'd2, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0;
    logic [9:0]  cfg_nsym = '0;
    logic        chip_valid = 1'b0;
    logic        chip_ready;
    logic [15:0] chip_re = '0;
    logic [15:0] chip_im = '0;
    logic        fft_in_valid;
    logic        fft_in_ready = 1'b0;
    logic [15:0] fft_in_re;
    logic [15:0] fft_in_im;
    logic        fft_in_last;
    logic        fft_out_valid = 1'b0;
    logic        fft_out_ready;
    logic [15:0] fft_out_re = '0;
    logic [15:0] fft_out_im = '0;
    logic        smp_valid;
    logic        smp_ready = 1'b0;
    logic [15:0] smp_re;
    logic [15:0] smp_im;
    logic        smp_frame_start;
    logic        smp_sym_start;

    int checks = 0;
    int failures = 0;

    logic src_en = 0, src_pause = 0, gap_on = 0, ifft_en = 0, thr_on = 0, snk_en = 0, bp_on = 0;
    logic m0 = 0, m1 = 0;
    int   n0 = 0, n1 = 0;

    mc_frame_asm uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_nsym(cfg_nsym),
        .chip_valid(chip_valid), .chip_ready(chip_ready), .chip_re(chip_re), .chip_im(chip_im),
        .fft_in_valid(fft_in_valid), .fft_in_ready(fft_in_ready), .fft_in_re(fft_in_re),
        .fft_in_im(fft_in_im), .fft_in_last(fft_in_last),
        .fft_out_valid(fft_out_valid), .fft_out_ready(fft_out_ready),
        .fft_out_re(fft_out_re), .fft_out_im(fft_out_im),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_re(smp_re), .smp_im(smp_im),
        .smp_frame_start(smp_frame_start), .smp_sym_start(smp_sym_start)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] cre(input int i); return 16'(i * 3 + 1); endfunction
    function automatic logic [15:0] cim(input int i); return 16'(20000 - i * 7); endfunction
    function automatic logic mode_of(input int f); return (f == 0) ? m0 : m1; endfunction
    function automatic int ns_of(input int f); return (f == 0) ? n0 : n1; endfunction
    function automatic logic b_used(input int k, input int nc, input int ncu);
        return (k > 0) && ((k <= ncu / 2) || (k >= nc - ncu / 2));
    endfunction
    function automatic int b_rank(input int k, input int nc, input int ncu);
        return (k <= ncu / 2) ? k - 1 : ncu / 2 + k - (nc - ncu / 2);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Chip source
    initial begin
        int idx = 0;
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!src_en) begin
                idx = 0;
                chip_valid = 1'b0;
            end else begin
                chip_valid = !src_pause && !(gap_on && (cyc % 7 < 2));
                chip_re = cre(idx);
                chip_im = cim(idx);
                #1;
                if (chip_valid && chip_ready) idx++;
            end
        end
    end

    // Identity transform model
    int r2_err = 0;
    initial begin
        logic [15:0] br [256];
        logic [15:0] bi [256];
        int cnt = 0, ret = 0, cyc = 0, isym = 0, ifrm = 0;
        logic returning = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!ifft_en) begin
                cnt = 0; ret = 0; returning = 0; isym = 0; ifrm = 0; r2_err = 0;
                fft_in_ready = 1'b0;
                fft_out_valid = 1'b0;
            end else if (returning) begin
                fft_in_ready = 1'b0;
                fft_out_valid = 1'b1;
                fft_out_re = br[ret];
                fft_out_im = bi[ret];
                #1;
                if (fft_out_ready) begin
                    ret++;
                    if (ret == cnt) begin returning = 0; cnt = 0; end
                end
            end else begin
                fft_out_valid = 1'b0;
                fft_in_ready = !(thr_on && (cyc % 4 == 1));
                #1;
                if (fft_in_valid && fft_in_ready) begin
                    br[cnt] = fft_in_re;
                    bi[cnt] = fft_in_im;
                    if (fft_in_last) begin
                        if (cnt + 1 != (mode_of(ifrm) ? 256 : 64)) r2_err++;
                        cnt++;
                        returning = 1; ret = 0;
                        isym++;
                        if (isym > ns_of(ifrm)) begin isym = 0; ifrm++; end
                    end else begin
                        cnt++;
                        if (cnt >= 256) r2_err++;
                    end
                end
            end
        end
    end

    // Output sink and reference model
    int syms_done = 0, frames_seen = 0, hold_err = 0;
    initial begin
        int s_sym = 0, s_p = 0, s_frame = 0, base = 0, cyc = 0;
        int nc = 64, g = 16, ncu = 48, ns = 0, k = 0, bad = 0;
        logic cm = 0;
        logic prev_hold = 0;
        logic [33:0] held, act, exp, bad_act, bad_exp;
        logic [15:0] er, ei;
        forever begin
            @(negedge clk);
            cyc++;
            if (!snk_en) begin
                s_sym = 0; s_p = 0; s_frame = 0; base = 0; syms_done = 0;
                frames_seen = 0; hold_err = 0; prev_hold = 0; bad = 0;
                smp_ready = 1'b0;
            end else begin
                smp_ready = !(bp_on && (cyc % 5 == 2));
                #1;
                act = {smp_re, smp_im, smp_frame_start, smp_sym_start};
                if (prev_hold && (!smp_valid || act != held)) hold_err++;
                prev_hold = smp_valid && !smp_ready;
                held = act;
                if (smp_valid && smp_ready) begin
                    if (s_p == 0) begin
                        if (s_sym == 0) begin cm = mode_of(s_frame); ns = ns_of(s_frame); end
                        nc = cm ? 256 : 64; g = cm ? 40 : 16; ncu = cm ? 192 : 48;
                        bad = 0;
                    end
                    k = (s_p < g) ? nc - g + s_p : s_p - g;
                    if (!b_used(k, nc, ncu)) begin er = '0; ei = '0; end
                    else if (s_sym == 0) begin er = 16'(PILOT); ei = '0; end
                    else begin
                        er = cre(base + b_rank(k, nc, ncu));
                        ei = cim(base + b_rank(k, nc, ncu));
                    end
                    exp = {er, ei, (s_p == 0 && s_sym == 0), (s_p == 0)};
                    if (smp_frame_start) frames_seen++;
                    if (act != exp && bad == 0) begin bad = 1; bad_act = act; bad_exp = exp; end
                    s_p++;
                    if (s_p == nc + g) begin
                        checks++;
                        if (bad != 0) begin
                            failures++;
                            $display("FAIL %s frame %0d sym %0d actual=%h expected=%h",
                                     (s_sym == 0) ? "R3 R5 R6" : "R4 R5 R2", s_frame, s_sym,
                                     bad_act, bad_exp);
                        end
                        if (s_sym != 0) base += ncu;
                        s_p = 0;
                        s_sym++;
                        if (s_sym > ns) begin s_sym = 0; s_frame++; end
                        syms_done++;
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #2; end
    endtask

    task automatic reset_all(input logic mode, input int ns);
        tick(1);
        src_en = 0; ifft_en = 0; snk_en = 0;
        src_pause = 0; gap_on = 0; bp_on = 0; thr_on = 0;
        rst_n = 1'b0;
        cfg_mode = mode; cfg_nsym = 10'(ns);
        m0 = mode; m1 = mode; n0 = ns; n1 = ns;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic run_on();
        src_en = 1; ifft_en = 1; snk_en = 1;
    endtask

    task automatic wait_syms(input int target, input string tag);
        int t = 0;
        while (syms_done < target && t < 40000) begin tick(1); t++; end
        chk(syms_done >= target, tag, syms_done, target);
    endtask

    initial begin
        int wd = 0;
        while (wd < 190000) begin @(posedge clk); wd++; end
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, 64-bin numerology
        reset_all(1'b0, 2);
        chk(smp_valid == 1'b0, "R1 smp_valid", smp_valid, 0);
        chk(fft_in_valid == 1'b1, "R1 first bin valid", fft_in_valid, 1);
        chk(fft_in_re == 16'd0 && fft_in_im == 16'd0, "R1 DC bin zero", fft_in_re, 0);
        chk(fft_in_last == 1'b0, "R1 not last", fft_in_last, 0);
        chk(chip_ready == 1'b0, "R1 pilot takes no chip", chip_ready, 0);

        // Table walk: R2 R3 R4 R5 R6 R8 R10
        for (int c = 0; c < 5; c++) begin
            reset_all(CASES[c].mode, int'(CASES[c].ns));
            gap_on = CASES[c].gap; bp_on = CASES[c].bp; thr_on = CASES[c].thr;
            run_on();
            wait_syms(int'(CASES[c].frames) * (int'(CASES[c].ns) + 1), "R4 symbol count");
            chk(frames_seen == int'(CASES[c].frames), "R6 frame markers", frames_seen,
                int'(CASES[c].frames));
            chk(r2_err == 0, "R2 last flag position", r2_err, 0);
            if (CASES[c].bp) chk(hold_err == 0, "R8 output hold", hold_err, 0);
            if (CASES[c].ns == 0) chk(syms_done == frames_seen, "R10 pilot-only frames",
                                      syms_done, frames_seen);
        end

        // R7: chips run dry after the pilot
        reset_all(1'b0, 2);
        src_pause = 1;
        run_on();
        tick(600);
        chk(syms_done == 1, "R7 only pilot leaves", syms_done, 1);
        chk(fft_in_valid == 1'b0, "R7 no filler bin", fft_in_valid, 0);
        chk(smp_valid == 1'b0, "R7 output idle", smp_valid, 0);
        src_pause = 0;
        wait_syms(3, "R7 resume");

        // R9: numerology switch partway through a frame
        reset_all(1'b0, 3);
        run_on();
        begin
            int t = 0;
            while (!(smp_valid && smp_ready) && t < 2000) begin tick(1); t++; end
        end
        cfg_mode = 1'b1; cfg_nsym = 10'd1; m1 = 1'b1; n1 = 1;
        wait_syms(6, "R9 frames across switch");
        chk(frames_seen == 2, "R9 frame markers", frames_seen, 2);
        chk(r2_err == 0, "R9 R2 symbol lengths", r2_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule